// File: doc/BRIEF.md
# Banked Logical-to-Physical Address MMU

This block sits between an 8-bit processor's 16-bit address bus and a 20-bit physical memory space of 1 MB. It divides the logical space into three regions: a lower common region starting at address zero, a bank region, and an upper common region. An 8-bit boundary register sets where the bank region and the upper common region start, in 4 KB steps. Two 8-bit base registers move the bank region and the upper common region to any 4 KB-aligned place in physical memory. The lower common region always passes through with no offset.

Translation is purely combinational. It depends only on the logical address and the current register contents, so there is no handshake on the address path and a new physical address appears in the same cycle as the logical address. Software programs the three registers through a small select/write/read port. A write is captured on the clock edge at the end of the write cycle.

Top module: `banked_mmu`

## Requirements
- R1: After reset the boundary register reads 8'hF0 and both base registers read 8'h00, so every logical address maps to the same address in the lowest 64 KB (`phys_addr == {4'h0, logical_addr}`).
- R2: The read data is combinational from `reg_sel`. Select 0 returns the boundary register, select 1 the upper common base, select 2 the bank base, and select 3 returns 8'h00.
- R3: When `reg_wr` is high, `reg_wdata` is stored into the selected register on the next rising clock edge. Before that edge, the read data and the translation still reflect the old value.
- R4: The upper field of the boundary register (bits [7:4]) holds the upper-region start. If `logical_addr[15:12]` is at or above this value, `region` is 2 and the upper common base is added.
- R5: The lower field of the boundary register (bits [3:0]) holds the bank start. If `logical_addr[15:12]` is below the upper start but at or above the bank start, `region` is 1 and the bank base is added.
- R6: If neither R4 nor R5 applies, `region` is 0 and `phys_addr == {4'h0, logical_addr}`.
- R7: `phys_addr = {4'h0, logical_addr} + {base, 12'h000}`, taken modulo 2^20. Bits [11:0] always equal the logical offset.
- R8: A boundary value whose upper field is smaller than its lower field is stored exactly as written. Decoding then follows the priority of R4 over R5.
- R9: When both fields are equal, the bank region is empty. When the lower field is 0, the lower common region is empty.
- R10: A write with select 3 changes none of the three registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 boundary, 1 upper base, 2 bank base, 3 none) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` |
| logical_addr | input | 16 | Logical address from the processor |
| phys_addr | output | 20 | Translated physical address |
| region | output | 2 | Selected region (0 lower, 1 bank, 2 upper) |

## Verification
The assertions check on every cycle that the reported region is consistent with the page bits and the stored boundary fields, and that the lower region passes through unchanged. They also check that the page offset is never altered, and that the boundary register changes only on a write that selects it. Other behaviour can only be shown by the bench's scenarios. This covers the exact relocated addresses, wrap-around past 1 MB, the empty-region cases, inverted boundaries, and the timing of a write relative to its clock edge.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  typedef enum logic [1:0] {
    RGN_LOWER = 2'd0,
    RGN_BANK  = 2'd1,
    RGN_UPPER = 2'd2
  } region_e;

  typedef enum logic [1:0] {
    SEL_BOUND = 2'd0,
    SEL_UBASE = 2'd1,
    SEL_KBASE = 2'd2,
    SEL_NONE  = 2'd3
  } regsel_e;
endpackage

// File: rtl/mmu_regfile.sv
module mmu_regfile #(
  parameter int BND_W  = 8,
  parameter int BASE_W = 8,
  parameter int DATA_W = 8,
  parameter logic [BND_W-1:0] BND_RST = 'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [BND_W-1:0]  bnd,
  output logic [BASE_W-1:0] ubase,
  output logic [BASE_W-1:0] kbase
);
  import mmu_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bnd   <= BND_RST;
      ubase <= '0;
      kbase <= '0;
    end else if (wr) begin
      case (regsel_e'(sel))
        SEL_BOUND: bnd   <= wdata[BND_W-1:0];
        SEL_UBASE: ubase <= wdata[BASE_W-1:0];
        SEL_KBASE: kbase <= wdata[BASE_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (regsel_e'(sel))
      SEL_BOUND: rdata[BND_W-1:0]  = bnd;
      SEL_UBASE: rdata[BASE_W-1:0] = ubase;
      SEL_KBASE: rdata[BASE_W-1:0] = kbase;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/mmu_region_decode.sv
module mmu_region_decode #(
  parameter int TAG_W = 4
) (
  input  logic [TAG_W-1:0]     page,
  input  logic [2*TAG_W-1:0]   bnd,
  output mmu_pkg::region_e     rgn
);
  import mmu_pkg::*;
  logic [TAG_W-1:0] upper_start;
  logic [TAG_W-1:0] bank_start;

  assign upper_start = bnd[2*TAG_W-1:TAG_W];
  assign bank_start  = bnd[TAG_W-1:0];

  always_comb begin
    if (page >= upper_start)     rgn = RGN_UPPER;
    else if (page >= bank_start) rgn = RGN_BANK;
    else                         rgn = RGN_LOWER;
  end
endmodule

// File: rtl/mmu_relocate.sv
module mmu_relocate #(
  parameter int LOG_W  = 16,
  parameter int PHY_W  = 20,
  parameter int PAGE_W = 12
) (
  input  logic [LOG_W-1:0]        laddr,
  input  mmu_pkg::region_e        rgn,
  input  logic [PHY_W-PAGE_W-1:0] ubase,
  input  logic [PHY_W-PAGE_W-1:0] kbase,
  output logic [PHY_W-1:0]        paddr
);
  import mmu_pkg::*;
  localparam int BASE_W = PHY_W - PAGE_W;

  logic [BASE_W-1:0] base_sel;
  logic [PHY_W-1:0]  ext_addr;
  logic [PHY_W-1:0]  offset;

  always_comb begin
    case (rgn)
      RGN_UPPER: base_sel = ubase;
      RGN_BANK:  base_sel = kbase;
      default:   base_sel = '0;
    endcase
  end

  generate
    if (PHY_W > LOG_W) begin : g_ext
      assign ext_addr = {{(PHY_W-LOG_W){1'b0}}, laddr};
    end else begin : g_trunc
      assign ext_addr = laddr[PHY_W-1:0];
    end
  endgenerate

  assign offset = {base_sel, {PAGE_W{1'b0}}};
  assign paddr  = ext_addr + offset;
endmodule

// File: rtl/banked_mmu.sv
module banked_mmu #(
  parameter int LOG_W  = 16,
  parameter int PHY_W  = 20,
  parameter int PAGE_W = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            reg_wr,
  input  logic [1:0]                      reg_sel,
  input  logic [2*(LOG_W-PAGE_W)-1:0]     reg_wdata,
  output logic [2*(LOG_W-PAGE_W)-1:0]     reg_rdata,
  input  logic [LOG_W-1:0]                logical_addr,
  output logic [PHY_W-1:0]                phys_addr,
  output logic [1:0]                      region
);
  import mmu_pkg::*;
  localparam int TAG_W  = LOG_W - PAGE_W;
  localparam int BND_W  = 2 * TAG_W;
  localparam int BASE_W = PHY_W - PAGE_W;
  localparam int DATA_W = BND_W;
  localparam logic [BND_W-1:0] BND_RST = {{TAG_W{1'b1}}, {TAG_W{1'b0}}};

  logic [BND_W-1:0]  bnd_q;
  logic [BASE_W-1:0] ubase_q;
  logic [BASE_W-1:0] kbase_q;
  region_e           rgn;

  mmu_regfile #(
    .BND_W(BND_W), .BASE_W(BASE_W), .DATA_W(DATA_W), .BND_RST(BND_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .bnd(bnd_q), .ubase(ubase_q), .kbase(kbase_q)
  );

  mmu_region_decode #(.TAG_W(TAG_W)) u_dec (
    .page(logical_addr[LOG_W-1:PAGE_W]), .bnd(bnd_q), .rgn(rgn)
  );

  mmu_relocate #(.LOG_W(LOG_W), .PHY_W(PHY_W), .PAGE_W(PAGE_W)) u_rel (
    .laddr(logical_addr), .rgn(rgn), .ubase(ubase_q), .kbase(kbase_q),
    .paddr(phys_addr)
  );

  assign region = rgn;
endmodule

// File: rtl/mmu_chk.sv
module mmu_chk #(
  parameter int LOG_W  = 16,
  parameter int PHY_W  = 20,
  parameter int PAGE_W = 12
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        reg_wr,
  input logic [1:0]                  reg_sel,
  input logic [2*(LOG_W-PAGE_W)-1:0] reg_wdata,
  input logic [LOG_W-1:0]            logical_addr,
  input logic [PHY_W-1:0]            phys_addr,
  input logic [1:0]                  region,
  input logic [2*(LOG_W-PAGE_W)-1:0] bnd_q
);
  localparam int TAG_W = LOG_W - PAGE_W;
  logic [TAG_W-1:0] page;
  assign page = logical_addr[LOG_W-1:PAGE_W];

  // R4
  upper_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 2'd2) |-> (page >= bnd_q[2*TAG_W-1:TAG_W]));

  // R5
  bank_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 2'd1) |-> (page >= bnd_q[TAG_W-1:0] && page < bnd_q[2*TAG_W-1:TAG_W]));

  // R6
  lower_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 2'd0) |-> (phys_addr == PHY_W'(logical_addr)));

  // R7
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[PAGE_W-1:0] == logical_addr[PAGE_W-1:0]);

  // R3
  bnd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0) |=> (bnd_q == $past(reg_wdata)));

  // R10
  bnd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_sel == 2'd0) |=> $stable(bnd_q));
endmodule

bind banked_mmu mmu_chk #(.LOG_W(LOG_W), .PHY_W(PHY_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .logical_addr(logical_addr), .phys_addr(phys_addr),
  .region(region), .bnd_q(bnd_q)
);

// File: tb/tb_banked_mmu.sv
module tb_banked_mmu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic [15:0] logical_addr = 16'h0000;
  logic [19:0] phys_addr;
  logic [1:0]  region;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] m_bnd = 8'hF0, m_ub = 8'h00, m_kb = 8'h00;

  logic [19:0] q_phys[$];
  logic [1:0]  q_rgn[$];
  string       q_tag[$];

  banked_mmu dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .logical_addr(logical_addr),
    .phys_addr(phys_addr), .region(region)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input logic [15:0] a, output logic [19:0] p, output logic [1:0] r);
    logic [7:0] b;
    if (a[15:12] >= m_bnd[7:4])      begin r = 2'd2; b = m_ub; end
    else if (a[15:12] >= m_bnd[3:0]) begin r = 2'd1; b = m_kb; end
    else                             begin r = 2'd0; b = 8'h00; end
    p = {4'h0, a} + {b, 12'h000};
  endtask

  task automatic xlate(input logic [15:0] a, input string tag);
    logic [19:0] p;
    logic [1:0]  r;
    @(posedge clk); #1;
    logical_addr = a;
    model(a, p, r);
    q_phys.push_back(p);
    q_rgn.push_back(r);
    q_tag.push_back(tag);
  endtask

  function automatic logic [7:0] shadow(input logic [1:0] s);
    case (s)
      2'd0: return m_bnd;
      2'd1: return m_ub;
      2'd2: return m_kb;
      default: return 8'h00;
    endcase
  endfunction

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    #1;
    check(reg_rdata == shadow(s), "R3 pre-edge old value", reg_rdata, shadow(s));
    @(posedge clk); #1;
    reg_wr = 1'b0;
    case (s)
      2'd0: m_bnd = d;
      2'd1: m_ub = d;
      2'd2: m_kb = d;
      default: ;
    endcase
    #1;
    check(reg_rdata == shadow(s), "R3 post-edge value", reg_rdata, shadow(s));
  endtask

  task automatic rd(input logic [1:0] s, input string tag);
    reg_sel = s; #1;
    check(reg_rdata == shadow(s), tag, reg_rdata, shadow(s));
  endtask

  // Monitor: pops one expected item per driven address
  always @(negedge clk) begin
    if (q_phys.size() > 0) begin
      logic [19:0] ep;
      logic [1:0]  er;
      string       t;
      ep = q_phys.pop_front();
      er = q_rgn.pop_front();
      t  = q_tag.pop_front();
      check(phys_addr == ep, {t, " phys"}, phys_addr, ep);
      check(region == er, {t, " region"}, region, er);
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset values
    reg_sel = 2'd0; #1;
    check(reg_rdata == 8'hF0, "R1 boundary reset", reg_rdata, 8'hF0);
    reg_sel = 2'd1; #1;
    check(reg_rdata == 8'h00, "R1 upper base reset", reg_rdata, 8'h00);
    reg_sel = 2'd2; #1;
    check(reg_rdata == 8'h00, "R1 bank base reset", reg_rdata, 8'h00);
    xlate(16'h0000, "R1 identity 0000");
    xlate(16'h1234, "R1 identity 1234");
    xlate(16'hEFFF, "R1 identity EFFF");
    xlate(16'hFFFF, "R1 identity FFFF");
    // R2 read of select 3
    @(posedge clk); #1;
    rd(2'd3, "R2 select3 reads zero");

    // R4 R5 R6 R7 three-region layout
    wr(2'd0, 8'h84);
    wr(2'd1, 8'h20);
    wr(2'd2, 8'h10);
    rd(2'd0, "R2 boundary readback");
    rd(2'd1, "R2 upper base readback");
    rd(2'd2, "R2 bank base readback");
    xlate(16'h3FFF, "R6 lower top");
    xlate(16'h4000, "R5 bank start");
    xlate(16'h7FFF, "R5 bank end");
    xlate(16'h8000, "R4 upper start");
    xlate(16'hFFFF, "R4 upper end");

    // R7 wrap past 1MB
    wr(2'd1, 8'hF8);
    xlate(16'hF123, "R7 wrap upper");
    wr(2'd2, 8'hFE);
    xlate(16'h5ABC, "R7 wrap bank");

    // R9 empty bank, empty lower
    wr(2'd0, 8'h55);
    xlate(16'h4FFF, "R9 empty bank lower");
    xlate(16'h5000, "R9 empty bank upper");
    wr(2'd0, 8'h90);
    xlate(16'h0000, "R9 empty lower bank");
    xlate(16'h9000, "R9 empty lower upper");

    // R8 inverted boundaries
    wr(2'd0, 8'h3A);
    @(posedge clk); #1;
    rd(2'd0, "R8 inverted stored");
    xlate(16'h2FFF, "R8 below both");
    xlate(16'h3000, "R8 upper priority");
    xlate(16'hA000, "R8 upper over bank");

    // R10 select-3 write ignored
    wr(2'd3, 8'hA5);
    @(posedge clk); #1;
    rd(2'd0, "R10 boundary unchanged");
    rd(2'd1, "R10 upper base unchanged");
    rd(2'd2, "R10 bank base unchanged");
    rd(2'd3, "R10 select3 still zero");
    xlate(16'h1000, "R10 translation unchanged");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule